// File: doc/BRIEF.md
# Configurable PAL Logic Core

This block models the logic core of a small reprogrammable array device. Eight dedicated inputs and eight feedback signals, one from each output cell, form sixteen array signals. Each signal reaches the AND array in true and complement form. Every one of the eight output cells owns eight product terms. A configuration word decides what each cell is: a clocked output, a combinatorial output whose enable comes from its first term, a combinatorial output that is always driven, or an input-only pin. The same word decides where each cell's feedback into the array comes from.

The fuse rows, their disable flags and the configuration word are loaded through a parallel port that only accepts writes while the program-enable input is high. The fuse memory is treated as non-volatile, so reset does not clear it. Reset clears only the cell registers. Each bidirectional pin is split into three vectors: a value coming in, a value going out, and a drive enable.

Top module: `pal_core`

## Requirements
- R1: Fuse row bit 2k connects the true form of array signal k and bit 2k+1 connects its complement. A bit value of 0 means connected. A term is high only when every connected literal is high, so an all-zero row is always low and an all-ones row is always high. Array signals 0 to 7 are `din[7:0]` and signals 8 to 15 are the cell feedbacks.
- R2: A row whose disable flag is set contributes 0 to its cell, whatever its fuses hold.
- R3: Fuse address `cell*8 + t` selects term t of a cell. Term 0 is included in the OR sum only when it is not serving as the cell's enable. Terms 1 to 7 are always included.
- R4: Configuration bit 8+i selects the polarity of cell i. A value of 1 passes the result as it is and 0 inverts it.
- R5: Global bits `cfg_word[17:16] = 2'b10` select registered mode. In that mode a cell with local bit i (bit i of the word) clear is registered: it captures the OR sum on the rising clock edge, drives the captured value through the polarity select, and is enabled exactly when `oe_n` is low.
- R6: In registered mode a cell with local bit i set is combinatorial. Term 0 is its enable and its feedback is its own `pin_in` bit.
- R7: Global bits `2'b11` select complex mode. Every cell is combinatorial, term 0 is its enable, and its feedback is its own `pin_in` bit.
- R8: Global bits `2'b01` or `2'b00` select simple mode. A cell with local bit set is input-only: enable 0 and output 0. Otherwise it is always enabled. The feedback of cell i is `pin_in[i^1]`.
- R9: The feedback of a registered cell is its register value.
- R10: Reset clears every cell register. A registered cell with inverting polarity therefore drives 1 after reset.
- R11: Writes to the fuse rows and to the configuration word are ignored while `prog_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell registers and the load port |
| rst_n | input | 1 | Active-low power-up reset of the cell registers |
| prog_en | input | 1 | Allows fuse and configuration writes while high |
| fuse_we | input | 1 | Fuse row write strobe |
| fuse_addr | input | 6 | Row index, cell*8 + term |
| fuse_row | input | 32 | Fuse bits of the row (0 means connected) |
| fuse_dis | input | 1 | Disable flag written with the row |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_word | input | 18 | {global[1:0], polarity[7:0], local[7:0]} |
| oe_n | input | 1 | External active-low enable for registered cells |
| din | input | 8 | Dedicated logic inputs |
| pin_in | input | 8 | Values present on the cell pins |
| pin_out | output | 8 | Values the cells drive onto their pins |
| pin_oe | output | 8 | Drive enables of the cell pins |

## Verification
Combinatorial outputs and all enables are due in the same cycle as the input change. The bench drives inputs on the falling edge and samples 1 ns later, before the next rising edge. A registered cell's output reflects the OR sum present at the rising edge and holds until the following one. The bench's reference therefore keeps its own register image, which it updates only at rising edges. Fuse and configuration writes take effect after the rising edge that captures them, so each directed check is placed one falling edge after its write.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Role a cell plays, decoded from global and local architecture bits.
  typedef enum logic [1:0] {
    ROLE_REG  = 2'd0,  // clocked output, external enable
    ROLE_CIO  = 2'd1,  // combinatorial, term 0 is the enable
    ROLE_COUT = 2'd2,  // combinatorial, always enabled
    ROLE_IN   = 2'd3   // input only
  } role_e;

  localparam logic [1:0] GSEL_REG  = 2'b10;
  localparam logic [1:0] GSEL_CPLX = 2'b11;

  function automatic role_e cell_role(input logic [1:0] gsel, input logic loc);
    role_e r;
    case (gsel)
      GSEL_REG:  r = loc ? ROLE_CIO : ROLE_REG;
      GSEL_CPLX: r = ROLE_CIO;
      default:   r = loc ? ROLE_IN : ROLE_COUT;
    endcase
    return r;
  endfunction

  // Simple-mode roles take feedback from the partner pin.
  function automatic logic uses_partner(input role_e r);
    return (r == ROLE_IN) || (r == ROLE_COUT);
  endfunction

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
  parameter int NROWS = 64,
  parameter int ROW_W = 32,
  parameter int CFG_W = 18,
  parameter int AW    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prog_en,
  input  logic                        fuse_we,
  input  logic [AW-1:0]               fuse_addr,
  input  logic [ROW_W-1:0]            fuse_row,
  input  logic                        fuse_dis,
  input  logic                        cfg_we,
  input  logic [CFG_W-1:0]            cfg_word,
  output logic [NROWS-1:0][ROW_W-1:0] rows_q,
  output logic [NROWS-1:0]            dis_q,
  output logic [CFG_W-1:0]            cfg_q
);

  // Named load events, visible to the assertions.
  logic row_load, cfg_load;
  assign row_load = prog_en & fuse_we;
  assign cfg_load = prog_en & cfg_we;

  // Non-volatile contents: deliberately not cleared by reset.
  always_ff @(posedge clk) begin
    if (row_load) begin
      rows_q[fuse_addr] <= fuse_row;
      dis_q[fuse_addr]  <= fuse_dis;
    end
    if (cfg_load) cfg_q <= cfg_word;
  end

  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(cfg_q));

  assert_rows_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> ($stable(rows_q) && $stable(dis_q)));

endmodule

// File: rtl/pal_and_array.sv
module pal_and_array #(
  parameter int NSIG  = 16,
  parameter int NROWS = 64,
  localparam int ROW_W = 2 * NSIG
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSIG-1:0]             sig,
  input  logic [NROWS-1:0][ROW_W-1:0] rows,
  input  logic [NROWS-1:0]            dis,
  output logic [NROWS-1:0]            term
);

  // A literal is checked only where its fuse is intact (0).
  function automatic logic row_hit(input logic [ROW_W-1:0] f, input logic [NSIG-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NSIG; k++) begin
      if (!f[2*k]   && !s[k]) ok = 1'b0;
      if (!f[2*k+1] &&  s[k]) ok = 1'b0;
    end
    return ok;
  endfunction

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic raw_hit;
    assign raw_hit = row_hit(rows[r], sig);
    assign term[r] = raw_hit & ~dis[r];

    assert_blank_row_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rows[r] == '0) |-> !term[r]);

    assert_open_row_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ((rows[r] == '1) && !dis[r]) |-> term[r]);

    assert_disabled_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dis[r] |-> !term[r]);
  end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_pkg::*;
#(
  parameter int NPT = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  role_e          role,
  input  logic           inv,
  input  logic [NPT-1:0] terms,
  input  logic           oe_n,
  output logic           pin_out,
  output logic           pin_oe,
  output logic           q
);

  logic pt0_is_oe, sum_all, sum_tail, sum;
  assign pt0_is_oe = (role == ROLE_CIO);
  assign sum_all   = |terms;
  assign sum_tail  = |terms[NPT-1:1];
  assign sum       = pt0_is_oe ? sum_tail : sum_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sum;
  end

  always_comb begin
    case (role)
      ROLE_REG:  begin pin_out = q ^ inv;   pin_oe = ~oe_n;    end
      ROLE_CIO:  begin pin_out = sum ^ inv; pin_oe = terms[0]; end
      ROLE_COUT: begin pin_out = sum ^ inv; pin_oe = 1'b1;     end
      default:   begin pin_out = 1'b0;      pin_oe = 1'b0;     end
    endcase
  end

  assert_reg_out_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && role == ROLE_REG && $stable(role) && $stable(inv))
      |-> (pin_out == ($past(sum) ^ inv)));

  assert_reg_oe_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_REG) |-> (pin_oe == !oe_n));

  assert_cio_oe_pt0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_CIO) |-> (pin_oe == terms[0]));

  assert_input_cell_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_IN) |-> (!pin_oe && !pin_out));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q == 1'b0));

endmodule

// File: rtl/pal_core.sv
module pal_core
  import pal_pkg::*;
#(
  parameter  int DIN_W = 8,
  parameter  int CELLS = 8,
  parameter  int NPT   = 8,
  localparam int NSIG  = DIN_W + CELLS,
  localparam int ROW_W = 2 * NSIG,
  localparam int NROWS = CELLS * NPT,
  localparam int AW    = $clog2(NROWS),
  localparam int CFG_W = 2 + 2 * CELLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic             fuse_we,
  input  logic [AW-1:0]    fuse_addr,
  input  logic [ROW_W-1:0] fuse_row,
  input  logic             fuse_dis,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             oe_n,
  input  logic [DIN_W-1:0] din,
  input  logic [CELLS-1:0] pin_in,
  output logic [CELLS-1:0] pin_out,
  output logic [CELLS-1:0] pin_oe
);

  logic [NROWS-1:0][ROW_W-1:0] rows_q;
  logic [NROWS-1:0]            dis_q;
  logic [CFG_W-1:0]            cfg_q;
  logic [NROWS-1:0]            term_v;
  logic [CELLS-1:0]            q_v, fb_v;
  logic [NSIG-1:0]             sig_v;
  logic [1:0]                  gsel;

  pal_fuse_store #(.NROWS(NROWS), .ROW_W(ROW_W), .CFG_W(CFG_W), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en),
    .fuse_we(fuse_we), .fuse_addr(fuse_addr), .fuse_row(fuse_row), .fuse_dis(fuse_dis),
    .cfg_we(cfg_we), .cfg_word(cfg_word),
    .rows_q(rows_q), .dis_q(dis_q), .cfg_q(cfg_q)
  );

  assign gsel  = cfg_q[CFG_W-1 -: 2];
  assign sig_v = {fb_v, din};

  pal_and_array #(.NSIG(NSIG), .NROWS(NROWS)) u_array (
    .clk(clk), .rst_n(rst_n), .sig(sig_v), .rows(rows_q), .dis(dis_q), .term(term_v)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    localparam int PARTNER = i ^ 1;
    role_e role_i;
    logic  inv_i;
    assign role_i = cell_role(gsel, cfg_q[i]);
    assign inv_i  = ~cfg_q[CELLS + i];

    always_comb begin
      if (role_i == ROLE_REG)        fb_v[i] = q_v[i];
      else if (uses_partner(role_i)) fb_v[i] = pin_in[PARTNER];
      else                           fb_v[i] = pin_in[i];
    end

    pal_macrocell #(.NPT(NPT)) u_mc (
      .clk(clk), .rst_n(rst_n), .role(role_i), .inv(inv_i),
      .terms(term_v[i*NPT +: NPT]), .oe_n(oe_n),
      .pin_out(pin_out[i]), .pin_oe(pin_oe[i]), .q(q_v[i])
    );

    assert_reg_feedback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (role_i == ROLE_REG) |-> (sig_v[DIN_W + i] == q_v[i]));

    assert_partner_feedback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gsel[1] == 1'b0) |-> (sig_v[DIN_W + i] == pin_in[PARTNER]));

    assert_cplx_own_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (gsel == GSEL_CPLX) |-> (sig_v[DIN_W + i] == pin_in[i] && pin_oe[i] == term_v[i*NPT]));
  end

endmodule

// File: tb/pal_core_tb.sv
`timescale 1ns/1ps
module pal_core_tb;

  logic        clk = 1'b0;
  logic        rst_n, prog_en, fuse_we, fuse_dis, cfg_we, oe_n;
  logic [5:0]  fuse_addr;
  logic [31:0] fuse_row;
  logic [17:0] cfg_word;
  logic [7:0]  din, pin_in, pin_out, pin_oe;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pal_core u_dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .fuse_we(fuse_we),
    .fuse_addr(fuse_addr), .fuse_row(fuse_row), .fuse_dis(fuse_dis),
    .cfg_we(cfg_we), .cfg_word(cfg_word), .oe_n(oe_n), .din(din),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Configurations: {global, polarity, local}
  localparam logic [17:0] CFG_L8  = {2'b11, 8'h00, 8'h00};  // all combinatorial, term-0 enable
  localparam logic [17:0] CFG_R8  = {2'b10, 8'h00, 8'h00};  // all registered
  localparam logic [17:0] CFG_MIX = {2'b10, 8'hA5, 8'hF0};  // registered + combinatorial
  localparam logic [17:0] CFG_SMP = {2'b01, 8'h69, 8'hC3};  // simple, four input-only cells
  localparam logic [17:0] CFGS [4] = '{CFG_L8, CFG_R8, CFG_MIX, CFG_SMP};

  // Stimulus vectors {oe_n, pin_in, din}
  localparam logic [16:0] STIM [12] = '{
    17'h00000, 17'h000FF, 17'h0FF00, 17'h1A55A, 17'h05AA5, 17'h11234,
    17'h0C3C3, 17'h13C3C, 17'h00F0F, 17'h1F0F0, 17'h08001, 17'h17E81 };

  logic [31:0] fz [64];
  logic        fd [64];
  logic [17:0] cur_cfg;
  logic [7:0]  ref_q;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] row_pat(input int r, input int salt);
    logic [31:0] v;
    v = '1;
    v[(r * 5 + salt) % 32] = 1'b0;
    if (r % 3 != 0) v[(r * 11 + 7 + salt) % 32] = 1'b0;
    return v;
  endfunction

  // Behavioural reference, written from the requirements.
  function automatic void ref_eval(input logic [17:0] c, input logic [7:0] d_in, input logic [7:0] p_in,
                                   input logic oen, input logic [7:0] qv,
                                   output logic [7:0] o, output logic [7:0] oe, output logic [7:0] nxt);
    logic [1:0]  g;
    logic [15:0] s;
    logic [7:0]  t;
    logic        lit, ctl, acc, regc;
    g = c[17:16];
    s[7:0] = d_in;
    for (int i = 0; i < 8; i++) begin
      if (g == 2'b10 && !c[i])         s[8+i] = qv[i];
      else if (g == 2'b10 || g == 2'b11) s[8+i] = p_in[i];
      else                             s[8+i] = p_in[i ^ 1];
    end
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        t[j] = !fd[i*8+j];
        for (int k = 0; k < 32; k++) begin
          if (!fz[i*8+j][k]) begin
            lit = (k % 2 == 0) ? s[k/2] : !s[k/2];
            if (!lit) t[j] = 1'b0;
          end
        end
      end
      regc = (g == 2'b10) && !c[i];
      ctl  = (g == 2'b11) || (g == 2'b10 && c[i]);
      acc  = 1'b0;
      for (int j = (ctl ? 1 : 0); j < 8; j++) acc = acc | t[j];
      nxt[i] = acc;
      if (regc)      begin o[i] = c[8+i] ? qv[i] : !qv[i]; oe[i] = !oen; end
      else if (ctl)  begin o[i] = c[8+i] ? acc : !acc;     oe[i] = t[0]; end
      else if (c[i]) begin o[i] = 1'b0;                    oe[i] = 1'b0; end
      else           begin o[i] = c[8+i] ? acc : !acc;     oe[i] = 1'b1; end
    end
  endfunction

  // Called just after a falling edge with inputs set; returns after the next falling edge.
  task automatic step_check(input string tag);
    logic [7:0] eo, eoe, nq;
    #1;
    ref_eval(cur_cfg, din, pin_in, oe_n, ref_q, eo, eoe, nq);
    check(pin_out == eo && pin_oe == eoe, tag, {pin_out, pin_oe}, {eo, eoe});
    @(posedge clk);
    ref_q = nq;
    @(negedge clk);
  endtask

  task automatic write_row(input int r);
    prog_en = 1'b1; fuse_we = 1'b1; fuse_addr = 6'(r); fuse_row = fz[r]; fuse_dis = fd[r];
    @(negedge clk);
    fuse_we = 1'b0; prog_en = 1'b0;
  endtask

  task automatic load_map(input int salt);
    for (int r = 0; r < 64; r++) begin
      fz[r] = row_pat(r, salt);
      fd[r] = (r % 7 == 3);
      write_row(r);
    end
  endtask

  task automatic load_cfg(input logic [17:0] c);
    prog_en = 1'b1; cfg_we = 1'b1; cfg_word = c;
    @(negedge clk);
    cfg_we = 1'b0; prog_en = 1'b0;
    cur_cfg = c;
  endtask

  task automatic pulse_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ref_q = 8'h00;
  endtask

  initial begin
    rst_n = 1'b0; prog_en = 1'b0; fuse_we = 1'b0; fuse_dis = 1'b0; cfg_we = 1'b0;
    fuse_addr = '0; fuse_row = '0; cfg_word = '0; oe_n = 1'b1; din = '0; pin_in = '0;
    ref_q = '0; cur_cfg = '0;
    @(negedge clk);

    // Vector table under each configuration (16L8-like, 16R8-like, mixed, simple)
    for (int p = 0; p < 4; p++) begin
      load_map(p == 1 ? 3 : 0);
      load_cfg(CFGS[p]);
      pulse_reset();
      for (int v = 0; v < 12; v++) begin
        {oe_n, pin_in, din} = STIM[v];
        case (p)
          0:       step_check("R1 R3 R4 R7 table");
          1:       step_check("R5 R9 R10 table");
          2:       step_check("R5 R6 R4 table");
          default: step_check("R8 R2 table");
        endcase
      end
    end

    // R10: registered inverting cells drive 1 right after reset
    load_cfg(CFG_R8);
    din = 8'hFF; pin_in = 8'h00; oe_n = 1'b0;
    pulse_reset();
    #1;
    check(pin_out == 8'hFF, "R10 reset output", {8'h00, pin_out}, 16'h00FF);
    check(pin_oe == 8'hFF, "R5 oe_n low enables", {8'h00, pin_oe}, 16'h00FF);
    oe_n = 1'b1;
    #1;
    check(pin_oe == 8'h00, "R5 oe_n high disables", {8'h00, pin_oe}, 16'h0000);
    @(negedge clk);

    // R11: writes with prog_en low leave configuration and fuses alone
    load_cfg(CFG_SMP);
    cfg_we = 1'b1; cfg_word = CFG_L8; fuse_we = 1'b1; fuse_addr = 6'd8;
    fuse_row = 32'h0; fuse_dis = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; fuse_we = 1'b0;
    #1;
    check(pin_oe == 8'h3C, "R11 cfg write blocked", {8'h00, pin_oe}, 16'h003C);
    step_check("R11 fuse write blocked");

    // R1/R2: cell 2 (simple output, inverting) with one open row then disabled
    for (int r = 16; r < 24; r++) begin fz[r] = 32'h0; fd[r] = 1'b0; write_row(r); end
    #1;
    check(pin_out[2] == 1'b1, "R1 all-zero rows low", {15'h0, pin_out[2]}, 16'h0001);
    @(negedge clk);
    fz[16] = '1; write_row(16);
    #1;
    check(pin_out[2] == 1'b0, "R1 open row high", {15'h0, pin_out[2]}, 16'h0000);
    @(negedge clk);
    fd[16] = 1'b1; write_row(16);
    #1;
    check(pin_out[2] == 1'b1, "R2 disabled row", {15'h0, pin_out[2]}, 16'h0001);
    @(negedge clk);

    // R8: cell 3 feedback comes from pin 2; only the true literal of signal 11
    for (int r = 24; r < 32; r++) begin fz[r] = 32'h0; fd[r] = 1'b0; write_row(r); end
    fz[24] = ~(32'h1 << 22); write_row(24);
    pin_in = 8'b0000_0100;
    #1;
    check(pin_out[3] == 1'b1, "R8 partner pin high", {15'h0, pin_out[3]}, 16'h0001);
    pin_in = 8'b0000_1000;
    #1;
    check(pin_out[3] == 1'b0, "R8 own pin ignored", {15'h0, pin_out[3]}, 16'h0000);
    @(negedge clk);

    // R8: global 2'b00 behaves as simple mode
    load_cfg({2'b00, 8'h69, 8'hC3});
    #1;
    check(pin_oe == 8'h3C, "R8 global 00 as simple", {8'h00, pin_oe}, 16'h003C);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule